// File: doc/BRIEF.md
# Two-Wire Row-Buffered EEPROM Slave

This block is the slave end of a two-wire serial link in front of a small non-volatile store of 32 rows, each 16 bits wide. The store is modelled as a register array. The bus lines are oversampled on the system clock. The block recognises START and STOP, then takes a control byte that names a row, a transfer mode and a direction. Every access moves a whole row into a 16-bit staging word. The serial side reads that word one byte at a time, or overwrites one or two of its bytes.

A write ends with STOP, which starts a timed programming cycle. First the target row is cleared (erase). After the programmed delay the staged word is committed. While this runs a busy flag is high and the slave drives nothing on the bus, so a master finds out that programming has finished by polling with control bytes until one is acknowledged. A read can run past the end of a row: the next row is fetched automatically, stepping up, stepping down, or staying on the same row, as the mode selects. Two write modes erase the whole store and fill it with zeros or with ones.

Top module: `eerow_slave`

## Requirements
- R1: After reset the data-line pull-down enable `sda_oe` is 0 and `busy` is 0.
- R2: After START the slave shifts in eight bits MSB first: row[4:0], mode[1:0], dir (dir=1 read, dir=0 write). When not busy it acknowledges the byte by holding `sda_oe` high through the ninth clock. It only turns the pull-down on while SCL is low.
- R3: While `busy` is 1 a control byte is not acknowledged and `sda_oe` stays 0. Once `busy` falls, the same control byte is acknowledged.
- R4: A write in mode 00 stores the first data byte in bits 15:8 of the row and the second in bits 7:0. The row is programmed on STOP and reads back with the new value.
- R5: Mode 01 moves the low byte (bits 7:0) first and the high byte second, for both reads and writes.
- R6: A write with one data byte changes only the byte that mode places first. The other byte keeps its old value.
- R7: In a write, a third data byte is not acknowledged and is not stored. The first two bytes are still programmed on STOP.
- R8: A read in mode 10 sends high then low. After both bytes it continues with row+1 modulo 32.
- R9: A read in mode 11 sends high then low. After both bytes it continues with row-1 modulo 32.
- R10: A read in mode 00 or 01 that goes on past two bytes sends the same row again.
- R11: A write control byte with mode 10 sets every row to 16'h0000, and one with mode 11 sets every row to 16'hFFFF. The row field is ignored. Data bytes that follow are not acknowledged, and the fill runs on STOP.
- R12: When the master does not acknowledge a read byte, the slave releases the line and drives nothing more until the next START.
- R13: `busy` rises on the clock after STOP is detected and stays high for exactly CYCLES_MS*PROG_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin (wired-AND) |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| busy | output | 1 | Programming cycle in progress |

## Verification
The assertions assume that the bus is slow relative to the system clock: every SCL level lasts several clocks, and SDA changes only while SCL is low, except at START and STOP. Under that assumption the acknowledge slot and the data bits line up with the sampled edges. The bench drives both lines with 8-clock half periods and moves SDA in the middle of the low phase. It ANDs the master's level with the slave's pull-down to model the shared line. Programming is shortened to 200 clocks, so that every row can be written and then read back in one run.

// File: rtl/eerow_pkg.sv
package eerow_pkg;

    localparam int ADDR_W = 5;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int ROWS   = 1 << ADDR_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        MD_HI_FIX = 2'b00,
        MD_LO_FIX = 2'b01,
        MD_UP     = 2'b10,
        MD_DOWN   = 2'b11
    } mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] row;
        mode_e             mode;
        logic              rd;
    } ctrl_t;

    function automatic logic lo_first(input mode_e m);
        return m == MD_LO_FIX;
    endfunction

    function automatic logic [ADDR_W-1:0] step_row(input logic [ADDR_W-1:0] r, input mode_e m);
        case (m)
            MD_UP:   return r + 1'b1;
            MD_DOWN: return r - 1'b1;
            default: return r;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] lead_byte(input logic [WORD_W-1:0] w, input mode_e m);
        return lo_first(m) ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] trail_byte(input logic [WORD_W-1:0] w, input mode_e m);
        return lo_first(m) ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/eerow_line_sampler.sv
module eerow_line_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic [SYNC-1:0] scl_q, sda_q;
    logic            scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC-2:0], scl_i};
            sda_q <= {sda_q[SYNC-2:0], sda_i};
            scl_d <= scl_q[SYNC-1];
            sda_d <= sda_q[SYNC-1];
        end
    end

    assign scl_s    = scl_q[SYNC-1];
    assign sda_s    = sda_q[SYNC-1];
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
    assign ev_rise  = scl_s & ~scl_d;
    assign ev_fall  = ~scl_s & scl_d;

endmodule

// File: rtl/eerow_prog_timer.sv
module eerow_prog_timer #(
    parameter int PROG_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch && !busy) begin
            busy <= 1'b1;
            cnt  <= CW'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    a_r13_starts: assert property (@(posedge clk) disable iff (rst)
        (launch && !busy) |=> busy);
    a_r13_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);
    a_r13_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0) |=> !busy);

endmodule

// File: rtl/eerow_store.sv
module eerow_store
    import eerow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_row,
    output logic [WORD_W-1:0] rd_word,
    input  logic              erase_go,
    input  logic              commit,
    input  logic [ADDR_W-1:0] tgt_row,
    input  logic [WORD_W-1:0] tgt_word,
    input  logic              fill_en,
    input  logic              fill_val
);
    logic [WORD_W-1:0] mem [ROWS];
    logic [ADDR_W-1:0] t_row;
    logic [WORD_W-1:0] t_word;
    logic              t_fill, t_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
            t_row  <= '0;
            t_word <= '0;
            t_fill <= 1'b0;
            t_val  <= 1'b0;
        end else if (erase_go) begin
            t_row  <= tgt_row;
            t_word <= tgt_word;
            t_fill <= fill_en;
            t_val  <= fill_val;
            if (fill_en) for (int i = 0; i < ROWS; i++) mem[i] <= '0;
            else         mem[tgt_row] <= '0;
        end else if (commit) begin
            if (t_fill) for (int i = 0; i < ROWS; i++) mem[i] <= {WORD_W{t_val}};
            else        mem[t_row] <= t_word;
        end
    end

    assign rd_word = mem[rd_row];

    a_r11_fill_all: assert property (@(posedge clk) disable iff (rst)
        (commit && t_fill) |=> (mem[0] == {WORD_W{t_val}} && mem[ROWS-1] == {WORD_W{t_val}}));

endmodule

// File: rtl/eerow_slave.sv
module eerow_slave
    import eerow_pkg::*;
#(
    parameter int CYCLES_MS = 125000,
    parameter int PROG_MS   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);
    localparam int PROG_CYCLES = CYCLES_MS * PROG_MS;

    logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;
    logic done, launch;

    phase_e            ph;
    logic [3:0]        bitc;
    logic [BYTE_W-1:0] sh, tx;
    ctrl_t             ctl;
    logic [WORD_W-1:0] wbuf, rd_word;
    logic [ADDR_W-1:0] rd_row;
    logic [1:0]        wcnt;
    logic              second, mack, wr_pend, fill_req;
    logic [BYTE_W-1:0] fb, sb, nfb;

    eerow_line_sampler #(.SYNC(2)) u_samp (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_rise(ev_rise), .ev_fall(ev_fall)
    );

    eerow_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .launch(launch), .busy(busy), .done(done)
    );

    eerow_store u_store (
        .clk(clk), .rst(rst), .rd_row(rd_row), .rd_word(rd_word),
        .erase_go(launch), .commit(done), .tgt_row(ctl.row), .tgt_word(wbuf),
        .fill_en(fill_req), .fill_val(ctl.mode[0])
    );

    assign launch = ev_stop && (wr_pend || fill_req) && !busy;
    assign rd_row = (ph == PH_CTRL) ? sh[BYTE_W-1:BYTE_W-ADDR_W] : step_row(ctl.row, ctl.mode);
    assign fb     = lead_byte(wbuf, ctl.mode);
    assign sb     = trail_byte(wbuf, ctl.mode);
    assign nfb    = lead_byte(rd_word, ctl.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            bitc     <= '0;
            sh       <= '0;
            tx       <= '0;
            ctl      <= '0;
            wbuf     <= '0;
            wcnt     <= '0;
            second   <= 1'b0;
            mack     <= 1'b0;
            wr_pend  <= 1'b0;
            fill_req <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev_start) begin
            ph       <= PH_CTRL;
            bitc     <= '0;
            wcnt     <= '0;
            wr_pend  <= 1'b0;
            fill_req <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev_stop) begin
            ph       <= PH_IDLE;
            wr_pend  <= 1'b0;
            fill_req <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ph != PH_IDLE && ph != PH_IGNORE) begin
            if (ev_rise) begin
                if (bitc < 4'd8)  sh   <= {sh[BYTE_W-2:0], sda_s};
                if (bitc == 4'd8) mack <= ~sda_s;
                bitc <= bitc + 1'b1;
            end
            if (ev_fall) begin
                if (bitc == 4'd8) begin
                    case (ph)
                        PH_CTRL: begin
                            if (busy) begin
                                ph <= PH_IGNORE;
                            end else begin
                                ctl    <= ctrl_t'(sh);
                                wbuf   <= rd_word;
                                sda_oe <= 1'b1;
                                if (!sh[0] && sh[2]) fill_req <= 1'b1;
                            end
                        end
                        PH_WDATA: begin
                            if (!fill_req && wcnt < 2'd2) begin
                                sda_oe  <= 1'b1;
                                wr_pend <= 1'b1;
                                wcnt    <= wcnt + 1'b1;
                                if ((wcnt == 2'd0) != lo_first(ctl.mode)) wbuf[WORD_W-1:BYTE_W] <= sh;
                                else                                      wbuf[BYTE_W-1:0]      <= sh;
                            end else begin
                                ph <= PH_IGNORE;
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (bitc == 4'd9) begin
                    bitc <= '0;
                    case (ph)
                        PH_CTRL: begin
                            if (ctl.rd) begin
                                ph     <= PH_RDATA;
                                second <= 1'b0;
                                tx     <= fb;
                                sda_oe <= ~fb[BYTE_W-1];
                            end else begin
                                ph     <= PH_WDATA;
                                sda_oe <= 1'b0;
                            end
                        end
                        PH_RDATA: begin
                            if (!mack) begin
                                ph     <= PH_IGNORE;
                                sda_oe <= 1'b0;
                            end else if (!second) begin
                                second <= 1'b1;
                                tx     <= sb;
                                sda_oe <= ~sb[BYTE_W-1];
                            end else begin
                                second  <= 1'b0;
                                ctl.row <= rd_row;
                                wbuf    <= rd_word;
                                tx      <= nfb;
                                sda_oe  <= ~nfb[BYTE_W-1];
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (ph == PH_RDATA) begin
                    tx     <= {tx[BYTE_W-2:0], 1'b0};
                    sda_oe <= ~tx[BYTE_W-2];
                end
            end
        end
    end

    a_r2_drive_when_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);
    a_r3_silent_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !sda_oe);
    a_r12_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IGNORE) |-> !sda_oe);
    a_r7_write_cap: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WDATA && wcnt == 2'd2 && ev_fall && bitc == 4'd8) |=> !sda_oe);

endmodule

// File: tb/tb_eerow_slave.sv
module tb_eerow_slave;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy, sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int busy_cnt = 0;

    logic [15:0] ref_mem [32];
    logic [7:0]  rbuf [80];

    always #4 clk = ~clk;

    assign sda_line = sda_oe ? 1'b0 : sda_m;

    eerow_slave #(.CYCLES_MS(20), .PROG_MS(10)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .busy(busy)
    );

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        w(4); sda_m = b; w(4); scl = 1'b1; w(8); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        w(4); sda_m = 1'b1; w(4); scl = 1'b1; w(4); b = sda_line; w(4); scl = 1'b0;
    endtask

    task automatic start_c();
        w(4); sda_m = 1'b1; w(4); scl = 1'b1; w(8); sda_m = 1'b0; w(8); scl = 1'b0;
    endtask

    task automatic stop_c();
        w(4); sda_m = 1'b0; w(4); scl = 1'b1; w(8); sda_m = 1'b1; w(8);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic open_txn(input logic [7:0] c);
        logic a;
        for (int t = 0; t < 200; t++) begin
            start_c();
            send_byte(c, a);
            if (a) return;
            stop_c();
        end
    endtask

    task automatic write_row(input logic [4:0] r, input logic [1:0] md, input int n,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic a;
        open_txn({r, md, 1'b0});
        if (n > 0) send_byte(b0, a);
        if (n > 1) send_byte(b1, a);
        if (n > 2) begin
            send_byte(b2, a);
            chk("R7 third byte ack", {31'b0, a}, 32'd0);
        end
        stop_c();
    endtask

    task automatic read_seq(input logic [4:0] r, input logic [1:0] md, input int n);
        logic b;
        open_txn({r, md, 1'b1});
        for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
        bit_in(b);
        chk("R12 line released after nack", {31'b0, b}, 32'd1);
        stop_c();
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        w(2);
    endtask

    function automatic logic [15:0] pat(input int r);
        logic [7:0] h, l;
        h = 8'((r * 9 + 1) & 8'hFF);
        l = 8'(8'hA5 ^ ((r * 3) & 8'hFF));
        return {h, l};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a;
        int b0;
        int idx;
        int rr;
        w(5);
        rst = 1'b0;
        w(4);
        // R1 reset state
        chk("R1 sda_oe after reset", {31'b0, sda_oe}, 32'd0);
        chk("R1 busy after reset", {31'b0, busy}, 32'd0);

        // R11 fill ones, row field 7 ignored; R2 ack when idle
        start_c();
        send_byte({5'd7, 2'b11, 1'b0}, a);
        chk("R2 control ack when idle", {31'b0, a}, 32'd1);
        send_byte(8'h5A, a);
        chk("R11 data after fill not acked", {31'b0, a}, 32'd0);
        b0 = busy_cnt;
        stop_c();
        chk("R13 busy raised after stop", {31'b0, busy}, 32'd1);
        // R3 poll while busy
        start_c();
        send_byte({5'd3, 2'b00, 1'b1}, a);
        chk("R3 no ack while busy", {31'b0, a}, 32'd0);
        stop_c();
        wait_idle();
        chk("R13 busy length", busy_cnt - b0, 32'd200);
        for (int i = 0; i < 32; i++) ref_mem[i] = 16'hFFFF;
        read_seq(5'd30, 2'b10, 4);
        chk("R11 fill ones row30", {16'b0, rbuf[0], rbuf[1]}, 32'hFFFF);
        chk("R11 fill ones row31", {16'b0, rbuf[2], rbuf[3]}, 32'hFFFF);

        // R4 sweep: write every row in mode 00, polling for ready
        for (int r = 0; r < 32; r++) begin
            write_row(5'(r), 2'b00, 2, pat(r)[15:8], pat(r)[7:0], 8'h00);
            ref_mem[r] = pat(r);
        end
        wait_idle();

        // R8 increment across all rows from 5 with wrap
        read_seq(5'd5, 2'b10, 66);
        for (int k = 0; k < 33; k++) begin
            rr = (5 + k) % 32;
            chk($sformatf("R4 R8 inc row %0d", rr), {16'b0, rbuf[2*k], rbuf[2*k+1]}, {16'b0, ref_mem[rr]});
        end

        // R9 decrement from 2 with wrap
        read_seq(5'd2, 2'b11, 12);
        for (int k = 0; k < 6; k++) begin
            rr = (2 - k + 32) % 32;
            chk($sformatf("R9 dec row %0d", rr), {16'b0, rbuf[2*k], rbuf[2*k+1]}, {16'b0, ref_mem[rr]});
        end

        // R10 fixed modes repeat the row
        read_seq(5'd9, 2'b00, 6);
        for (int k = 0; k < 3; k++)
            chk("R10 mode00 repeat", {16'b0, rbuf[2*k], rbuf[2*k+1]}, {16'b0, ref_mem[9]});
        read_seq(5'd12, 2'b01, 4);
        // R5 low first
        chk("R5 R10 mode01 read", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]},
            {ref_mem[12][7:0], ref_mem[12][15:8], ref_mem[12][7:0], ref_mem[12][15:8]});

        // R5 low-first write
        write_row(5'd13, 2'b01, 2, 8'h11, 8'h22, 8'h00);
        ref_mem[13] = 16'h2211;
        // R6 single byte writes
        write_row(5'd14, 2'b00, 1, 8'h3C, 8'h00, 8'h00);
        ref_mem[14] = {8'h3C, ref_mem[14][7:0]};
        write_row(5'd15, 2'b01, 1, 8'hC3, 8'h00, 8'h00);
        ref_mem[15] = {ref_mem[15][15:8], 8'hC3};
        // R7 third byte dropped
        write_row(5'd16, 2'b00, 3, 8'h81, 8'h42, 8'hEE);
        ref_mem[16] = 16'h8142;
        wait_idle();
        read_seq(5'd13, 2'b10, 8);
        chk("R5 mode01 write", {16'b0, rbuf[0], rbuf[1]}, {16'b0, ref_mem[13]});
        chk("R6 one byte hi", {16'b0, rbuf[2], rbuf[3]}, {16'b0, ref_mem[14]});
        chk("R6 one byte lo", {16'b0, rbuf[4], rbuf[5]}, {16'b0, ref_mem[15]});
        chk("R7 two bytes kept", {16'b0, rbuf[6], rbuf[7]}, {16'b0, ref_mem[16]});

        // R11 fill zeros with row field 31
        open_txn({5'd31, 2'b10, 1'b0});
        stop_c();
        wait_idle();
        read_seq(5'd0, 2'b11, 4);
        chk("R11 fill zeros row0", {16'b0, rbuf[0], rbuf[1]}, 32'd0);
        chk("R11 fill zeros row31", {16'b0, rbuf[2], rbuf[3]}, 32'd0);
        idx = 0;
        chk("R1 sda idle at end", {31'b0, sda_oe}, 32'(idx));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule